// File: doc/BRIEF.md
# Serial Character Transmitter with Line Control

This block turns parallel characters into an asynchronous serial bit stream on one output wire. A character is written into a one-entry holding register. When the internal shifter is free, the character moves into it and is sent as a frame: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or more high stop bits. A baud strobe arrives from outside at sixteen times the bit rate. Every bit of the frame lasts a fixed number of those strobes.

A set of line-control inputs selects the word length, the stop-bit count, whether parity is sent, odd or even sense, and stick parity. Stick parity forces the parity bit to a constant mark (1) or space (0). The line-control settings are captured when a character enters the shifter, so changing them mid-frame does not affect the frame in flight.

A break input pulls the output pin low. The break acts on the pin only: the shifter and both empty flags keep working underneath. Software can therefore time a break by sending characters while it is active. Two status outputs tell the host when the holding register can take another byte and when the whole transmit path has gone quiet.

Top module: `serial_tx_line`

## Requirements
- R1: After synchronous reset, `txd` is 1 and both `hold_empty` and `tx_empty` are 1. This holds even when reset arrives in the middle of a frame.
- R2: A frame is a 0 start bit, then N data bits sent LSB first, then stop bits at 1. N is 5, 6, 7 or 8 for `lc_wlen` 0, 1, 2 or 3. Each bit lasts TICKS_PER_BIT (default 16) `tick` strobes.
- R3: When `lc_par_en`=1 and `lc_par_stick`=0, one parity bit follows the data. With `lc_par_even`=0 the data bits plus parity hold an odd number of ones; with `lc_par_even`=1 they hold an even number. When `lc_par_en`=0, no parity bit is sent.
- R4: When `lc_par_en`=1 and `lc_par_stick`=1, the parity bit is a constant: 0 (space) if `lc_par_even`=1, and 1 (mark) if `lc_par_even`=0.
- R5: The stop period is set by `lc_two_stop`. With `lc_two_stop`=0 it is one bit time. With `lc_two_stop`=1 it is two bit times, or one and a half bit times when N=5. `tx_empty` rises in the cycle after the stop period ends.
- R6: Writing (`wr_en`=1) clears `hold_empty` and `tx_empty` at the next edge. When the shifter is idle, the character moves into it on the following edge and `hold_empty` returns to 1 at that moment. `tx_empty` implies `hold_empty`.
- R7: While `lc_break`=1, `txd` is 0. When `lc_break` returns to 0, `txd` again follows the shifter, which is 1 when idle.
- R8: Break does not alter the shifter. A character written during a break raises `tx_empty` after exactly the same number of cycles as it would without the break.
- R9: Bit timing advances only on `tick` strobes. With `tick` held at 0, a frame in flight holds its current bit level on `txd`.
- R10: A character written while the previous one is being sent starts one clock after the previous frame's stop period ends, and `tx_empty` stays 0 across both frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Baud strobe at TICKS_PER_BIT times the bit rate |
| lc_wlen | input | 2 | Word length select: 0..3 selects 5..8 data bits |
| lc_two_stop | input | 1 | Longer stop period: 2 bits, or 1.5 bits for 5-bit words |
| lc_par_en | input | 1 | Send a parity bit |
| lc_par_even | input | 1 | Even parity sense; with stick parity, selects space |
| lc_par_stick | input | 1 | Force the parity bit to a constant |
| lc_break | input | 1 | Force the output pin low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The bench decodes every frame across all four word lengths. It covers odd, even, mark and space parity, and one, one-and-a-half and two stop bits. A wrong parity rule shows up as a flipped parity sample. A word-length decode error moves the parity or stop bit, and a miscounted stop period moves the `tx_empty` rise by eight or sixteen cycles. The break test sends a character under break and expects both a constant low line and unchanged `tx_empty` timing. A design that gates the shifter with break would finish late; one that muxes break in the wrong place would leak ones. Further directed tests cover a stalled baud strobe (the start bit must hold), a back-to-back pair (the second start must follow after exactly one idle cycle), and reset in mid-frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned MAX_BITS = 8;
    localparam int unsigned MIN_BITS = 5;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } line_ctl_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // Parity bit for a character under the given line settings.
    function automatic logic parity_bit(logic [MAX_BITS-1:0] d, line_ctl_t c);
        logic [MAX_BITS-1:0] mask;
        logic ones_odd;
        mask     = {MAX_BITS{1'b1}} >> (2'd3 - c.wlen);
        ones_odd = ^(d & mask);
        if (c.par_stick)
            return ~c.par_even;
        return c.par_even ? ones_odd : ~ones_odd;
    endfunction

    // Length of the stop period in baud strobes.
    function automatic int unsigned stop_ticks(line_ctl_t c, int unsigned tpb);
        if (!c.two_stop)
            return tpb;
        if (c.wlen == 2'd0)
            return tpb + tpb / 2;
        return 2 * tpb;
    endfunction

endpackage

// File: rtl/sertx_holding.sv
module sertx_holding
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic                take,
    output logic [MAX_BITS-1:0] hold_data,
    output logic                hold_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                hold_full,
    input  logic [MAX_BITS-1:0] hold_data,
    input  line_ctl_t           ctl,
    output logic                take,
    output logic                line_raw,
    output logic                busy
);

    localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT);
    localparam int unsigned IDX_W = $clog2(MAX_BITS);

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_last;
    logic [MAX_BITS-1:0] sr_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    last_idx_q;
    logic [CNT_W-1:0]    stop_last_q;
    logic                par_en_q;
    logic                par_q;

    assign take     = (phase_q == PH_IDLE) && hold_full;
    assign busy     = (phase_q != PH_IDLE);
    assign cnt_last = (phase_q == PH_STOP) ? stop_last_q : CNT_W'(TICKS_PER_BIT - 1);

    always_comb begin
        case (phase_q)
            PH_START: line_raw = 1'b0;
            PH_DATA:  line_raw = sr_q[0];
            PH_PAR:   line_raw = par_q;
            default:  line_raw = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            sr_q        <= '0;
            idx_q       <= '0;
            last_idx_q  <= '0;
            stop_last_q <= '0;
            par_en_q    <= 1'b0;
            par_q       <= 1'b0;
        end else if (take) begin
            phase_q     <= PH_START;
            cnt_q       <= '0;
            sr_q        <= hold_data;
            idx_q       <= '0;
            last_idx_q  <= IDX_W'(MIN_BITS - 1 + 32'(ctl.wlen));
            stop_last_q <= CNT_W'(stop_ticks(ctl, TICKS_PER_BIT) - 1);
            par_en_q    <= ctl.par_en;
            par_q       <= parity_bit(hold_data, ctl);
        end else if (busy && tick) begin
            if (cnt_q == cnt_last) begin
                cnt_q <= '0;
                case (phase_q)
                    PH_START: phase_q <= PH_DATA;
                    PH_DATA: begin
                        if (idx_q == last_idx_q) begin
                            phase_q <= par_en_q ? PH_PAR : PH_STOP;
                        end else begin
                            sr_q  <= sr_q >> 1;
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    PH_PAR:  phase_q <= PH_STOP;
                    default: phase_q <= PH_IDLE;
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sertx_line_drive.sv
module sertx_line_drive (
    input  logic line_raw,
    input  logic brk,
    output logic txd
);

    // Break acts at the pin only; the shifter below is untouched.
    assign txd = line_raw & ~brk;

endmodule

// File: rtl/serial_tx_line.sv
module serial_tx_line
    import sertx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] lc_wlen,
    input  logic       lc_two_stop,
    input  logic       lc_par_en,
    input  logic       lc_par_even,
    input  logic       lc_par_stick,
    input  logic       lc_break,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    line_ctl_t           ctl;
    logic                take;
    logic                hold_full;
    logic                busy;
    logic                line_raw;
    logic [MAX_BITS-1:0] hold_data;

    assign ctl = '{wlen: lc_wlen, two_stop: lc_two_stop, par_en: lc_par_en,
                   par_even: lc_par_even, par_stick: lc_par_stick};

    sertx_holding u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    sertx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .ctl       (ctl),
        .take      (take),
        .line_raw  (line_raw),
        .busy      (busy)
    );

    sertx_line_drive u_drive (
        .line_raw (line_raw),
        .brk      (lc_break),
        .txd      (txd)
    );

    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic wr_en,
    input logic lc_break,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty
);

    assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
        lc_break |-> !txd);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !lc_break) |-> txd);

    assert_empty_order_R6: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

    assert_write_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!hold_empty && !tx_empty));

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && hold_empty && !tx_empty && !lc_break) |=> ($stable(txd) || lc_break));

endmodule

bind serial_tx_line sertx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wr_en      (wr_en),
    .lc_break   (lc_break),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/serial_tx_line_test.sv
module serial_tx_line_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] lc_wlen = 2'd3;
    logic       lc_two_stop = 1'b0;
    logic       lc_par_en = 1'b0;
    logic       lc_par_even = 1'b0;
    logic       lc_par_stick = 1'b0;
    logic       lc_break = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    logic line_s [0:511];
    logic emp_s  [0:511];
    logic hold_s [0:511];

    always #4 clk = ~clk;

    serial_tx_line uut (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .lc_wlen      (lc_wlen),
        .lc_two_stop  (lc_two_stop),
        .lc_par_en    (lc_par_en),
        .lc_par_even  (lc_par_even),
        .lc_par_stick (lc_par_stick),
        .lc_break     (lc_break),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .txd          (txd),
        .hold_empty   (hold_empty),
        .tx_empty     (tx_empty)
    );

    // data, wlen, two_stop, par_en, par_even, par_stick
    localparam logic [13:0] VECS [8] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hA5, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hA5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h13, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h3C, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h7F, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hFF, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nbits(logic [1:0] w);
        return 5 + int'(w);
    endfunction

    function automatic logic exp_parity(logic [7:0] d, logic [1:0] w, logic ev, logic st);
        int ones = 0;
        if (st) return ~ev;
        for (int i = 0; i < nbits(w); i++) ones += int'(d[i]);
        if (ev) return (ones % 2) == 1;
        return (ones % 2) == 0;
    endfunction

    function automatic int frame_len(logic [13:0] v);
        int n = nbits(v[5:4]);
        int sl = v[3] ? ((n == 5) ? 24 : 32) : 16;
        return 16 * (1 + n + int'(v[2])) + sl;
    endfunction

    // Write one character and record the ports for count cycles after the write edge.
    task automatic capture(input logic [13:0] v, input int count);
        @(negedge clk);
        {lc_wlen, lc_two_stop, lc_par_en, lc_par_even, lc_par_stick} = v[5:0];
        wr_data = v[13:6];
        wr_en   = 1'b1;
        for (int k = 1; k <= count; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            line_s[k] = txd;
            emp_s[k]  = tx_empty;
            hold_s[k] = hold_empty;
        end
    endtask

    task automatic run_frame(input logic [13:0] v);
        int n = nbits(v[5:4]);
        int p = int'(v[2]);
        int len = frame_len(v);
        logic par;
        par = exp_parity(v[13:6], v[5:4], v[1], v[0]);
        capture(v, len + 2);
        check(line_s[1] == 1'b1, "R6 idle before transfer", line_s[1], 1);
        check(hold_s[1] == 1'b0 && emp_s[1] == 1'b0, "R6 write clears flags", hold_s[1], 0);
        check(hold_s[2] == 1'b1, "R6 hold_empty on transfer", hold_s[2], 1);
        check(line_s[2] == 1'b0 && line_s[17] == 1'b0, "R2 start bit", line_s[17], 0);
        for (int i = 0; i < n; i++)
            check(line_s[9 + 16 * (i + 1)] == v[6 + i], "R2 data bit", line_s[9 + 16 * (i + 1)], v[6 + i]);
        if (p == 1) begin
            if (v[0])
                check(line_s[9 + 16 * (n + 1)] == par, "R4 stick parity", line_s[9 + 16 * (n + 1)], par);
            else
                check(line_s[9 + 16 * (n + 1)] == par, "R3 parity", line_s[9 + 16 * (n + 1)], par);
        end
        check(line_s[2 + 16 * (1 + n + p)] == 1'b1 && line_s[len + 1] == 1'b1, "R2 stop level",
              line_s[len + 1], 1);
        check(emp_s[len + 1] == 1'b0, "R5 stop period not short", emp_s[len + 1], 0);
        check(emp_s[len + 2] == 1'b1, "R5 tx_empty after stop", emp_s[len + 2], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle high", txd, 1);
        check(hold_empty == 1'b1 && tx_empty == 1'b1, "R1 flags set", {hold_empty, tx_empty}, 3);

        // R2 R3 R4 R5 vector walk
        foreach (VECS[i]) begin
            run_frame(VECS[i]);
            @(negedge clk);
        end

        // R7 R8 break: line held low, shifter timing unchanged
        begin
            int len = frame_len(VECS[1]);
            int ones = 0;
            @(negedge clk);
            lc_break = 1'b1;
            @(negedge clk);
            check(txd == 1'b0, "R7 break forces low", txd, 0);
            capture(VECS[1], len + 2);
            for (int k = 1; k <= len + 2; k++) ones += int'(line_s[k]);
            check(ones == 0, "R7 line low during break", ones, 0);
            check(emp_s[len + 1] == 1'b0 && emp_s[len + 2] == 1'b1, "R8 timing under break",
                  emp_s[len + 2], 1);
            @(negedge clk);
            lc_break = 1'b0;
            @(negedge clk);
            check(txd == 1'b1, "R7 break cleared", txd, 1);
        end

        // R10 back-to-back characters
        begin
            logic [13:0] va = VECS[0];
            logic [13:0] vb = {8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0};
            int la = frame_len(va);
            int lb = frame_len(vb);
            int tot = la + lb + 3;
            @(negedge clk);
            {lc_wlen, lc_two_stop, lc_par_en, lc_par_even, lc_par_stick} = va[5:0];
            wr_data = va[13:6];
            wr_en = 1'b1;
            for (int k = 1; k <= tot; k++) begin
                @(negedge clk);
                wr_en = 1'b0;
                if (k == 2) begin
                    wr_data = vb[13:6];
                    wr_en = 1'b1;
                end
                line_s[k] = txd;
                emp_s[k]  = tx_empty;
            end
            check(line_s[la + 2] == 1'b1, "R10 one idle cycle", line_s[la + 2], 1);
            check(line_s[la + 3] == 1'b0, "R10 second start", line_s[la + 3], 0);
            check(line_s[la + 3 + 8 + 16] == vb[6], "R10 second data bit 0", line_s[la + 27], vb[6]);
            check(emp_s[la + 2] == 1'b0 && emp_s[tot - 1] == 1'b0, "R10 tx_empty held low",
                  emp_s[la + 2], 0);
            check(emp_s[tot] == 1'b1, "R10 tx_empty at end", emp_s[tot], 1);
        end

        // R9 stalled strobe holds the start bit
        @(negedge clk);
        tick = 1'b0;
        capture(VECS[0], 40);
        check(line_s[40] == 1'b0, "R9 start held while stalled", line_s[40], 0);
        check(emp_s[40] == 1'b0, "R9 still busy while stalled", emp_s[40], 0);
        tick = 1'b1;
        for (int k = 0; k < 400 && !tx_empty; k++) @(negedge clk);
        check(tx_empty == 1'b1 && txd == 1'b1, "R9 resumes and completes", tx_empty, 1);

        // R1 reset in mid-frame
        capture(VECS[2], 30);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && hold_empty == 1'b1 && tx_empty == 1'b1, "R1 reset mid-frame",
              {txd, hold_empty, tx_empty}, 7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule